// File: doc/BRIEF.md
# Programmable system clock tree

This block forms the system, bus, peripheral-bus, timer and kernel clock strobes of a small microcontroller from four primary sources: a fast internal oscillator, a high-speed external clock, a low-speed internal clock and a low-speed external clock. All clocks are modelled as single-cycle enables on one fast reference clock `clk`. Each primary source arrives as a strobe input, and each derived clock leaves as a strobe output. The fast oscillator feeds a power-of-two divider. A source selector then chooses among the divided oscillator and the three other sources to form the system clock. A bus divider, a fixed divide-by-eight tap, a peripheral-bus divider and a timer derivation follow. A separate kernel divider runs directly from the fast oscillator.

Settings arrive over a write-only port. Each write carries a 3-bit address and a 4-bit value. Every divider field is a power-of-two code, and a code above a divider's maximum saturates at that maximum. Writing a divider restarts its phase.

A source change is made by a small switching state machine with three states:
- `SW_RUN`: passes the active source.
- `SW_DRAIN`: lets the current period of the old source finish.
- `SW_ARM`: holds the system strobe low until one strobe of the new source is seen, then commits.

The transitions are:
- RUN→DRAIN on an accepted request.
- DRAIN→ARM on a strobe of the old source.
- ARM→RUN on a strobe of the new source.

The `active_src` output reports the source in use, and `switch_busy` is high while a change is pending.

Top module: `sys_clock_tree`

## Requirements
- R1: After reset the selected source is code 0 (divided oscillator), the oscillator divider code is 2 (divide by 4), all other divider codes are 0, `active_src` is 0 and `switch_busy` is 0.
- R2: Address 1 sets the oscillator divider. `osc_tick` is divided by 2^min(code,7).
- R3: A divider output fires only on a strobe of its input, and only once every F input strobes. A write to a divider restarts its count, so its first output is the F-th input strobe after the write cycle. In the write cycle itself the old setting still applies.
- R4: Address 2 sets the bus divider. `ahb_tick` is `sys_tick` divided by 2^min(code,9).
- R5: `ahb8_tick` fires on every eighth `ahb_tick`, counted from reset.
- R6: Address 3 sets the peripheral-bus divider. `apb_tick` is `ahb_tick` divided by F = 2^min(code,4).
- R7: When F = 1, `tim_tick` equals `apb_tick`. Otherwise `tim_tick` is `ahb_tick` divided by F/2, and every `apb_tick` coincides with a `tim_tick`.
- R8: Address 4 sets the kernel divider. `ker_tick` is `osc_tick` divided by 2^min(code,3), independent of the selected source.
- R9: Address 0 requests a source with `wr_data[1:0]`: 0 is the divided oscillator, 1 is the high-speed external clock, 2 is the low-speed internal clock and 3 is the low-speed external clock. A request equal to `active_src`, or one made while `switch_busy` is 1, is ignored.
- R10: After an accepted request, `sys_tick` keeps following the old source up to and including its next strobe. It is then 0 until a strobe of the new source, which is absorbed. At that point `active_src` takes the new code and `switch_busy` falls. `switch_busy` is 1 from the cycle after the request.
- R11: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Fast internal oscillator strobe |
| hse_tick | input | 1 | High-speed external clock strobe |
| lsi_tick | input | 1 | Low-speed internal clock strobe |
| lse_tick | input | 1 | Low-speed external clock strobe |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 3 | Setting address |
| wr_data | input | 4 | Setting value |
| sys_tick | output | 1 | System clock strobe |
| ahb_tick | output | 1 | Bus clock strobe |
| ahb8_tick | output | 1 | Bus clock divided by eight |
| apb_tick | output | 1 | Peripheral-bus clock strobe |
| tim_tick | output | 1 | Timer clock strobe |
| ker_tick | output | 1 | Kernel clock strobe |
| active_src | output | 2 | Source code currently in use |
| switch_busy | output | 1 | Source change in progress |

## Verification
The bench builds the block with its default parameters: maximum exponents of 7, 9, 4 and 3, and 4-bit codes. With these values a code of 12 reaches bus-divider saturation and a code of 5 reaches peripheral-divider saturation. A behavioural model compares every output strobe on every clock. The oscillator strobe is run both continuously and at half rate, and the three other sources run at unrelated periods, so that source switches meet old and new strobes at varied offsets. One directed sweep covers every peripheral-divider code, including a saturating one, and counts timer strobes against peripheral strobes.

// File: rtl/clktree_pkg.sv
package clktree_pkg;

    typedef enum logic [1:0] {
        SRC_OSCDIV = 2'd0,
        SRC_HSE    = 2'd1,
        SRC_LSI    = 2'd2,
        SRC_LSE    = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_ARM   = 2'd2
    } sw_state_e;

    localparam logic [2:0] ADDR_SRC = 3'd0;
    localparam logic [2:0] ADDR_OSC = 3'd1;
    localparam logic [2:0] ADDR_AHB = 3'd2;
    localparam logic [2:0] ADDR_APB = 3'd3;
    localparam logic [2:0] ADDR_KER = 3'd4;

    function automatic logic [3:0] sat_code(input logic [3:0] code, input int unsigned max_code);
        if (32'(code) > max_code) return 4'(max_code);
        return code;
    endfunction

endpackage

// File: rtl/ct_pow2_div.sv
module ct_pow2_div #(
    parameter int MAX_LOG2   = 7,
    parameter int CODE_W     = 4,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tick,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    output logic              out_tick
);
    localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
    localparam int LOG_W = (MAX_LOG2 < 1) ? 1 : $clog2(MAX_LOG2 + 1);

    logic [LOG_W-1:0] code_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] terminal;
    logic [LOG_W-1:0] code_sat;

    always_comb begin
        one_sh   = (CNT_W + 1)'(1) << code_q;
        terminal = CNT_W'(one_sh - (CNT_W + 1)'(1));
        code_sat = (32'(load_code) > 32'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : LOG_W'(load_code);
        out_tick = in_tick && (cnt_q == terminal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= LOG_W'(RESET_CODE);
            cnt_q  <= '0;
        end else if (load) begin
            code_q <= code_sat;
            cnt_q  <= '0;
        end else if (in_tick) begin
            cnt_q  <= (cnt_q == terminal) ? '0 : cnt_q + 1'b1;
        end
    end

    // Back-to-back outputs only when the factor is one (R3)
    assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && $past(out_tick) && !$past(load)) |-> (code_q == '0));

endmodule

// File: rtl/ct_src_switch.sv
module ct_src_switch
    import clktree_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_ticks,
    input  logic       req_valid,
    input  logic [1:0] req_src,
    output logic       sys_tick,
    output logic [1:0] active_src,
    output logic       busy
);
    sw_state_e  state_q, state_d;
    logic [1:0] active_q, active_d;
    logic [1:0] pend_q, pend_d;

    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        pend_d   = pend_q;
        unique case (state_q)
            SW_RUN: begin
                if (req_valid && (req_src != active_q)) begin
                    pend_d  = req_src;
                    state_d = SW_DRAIN;
                end
            end
            SW_DRAIN: begin
                if (src_ticks[active_q]) state_d = SW_ARM;
            end
            SW_ARM: begin
                if (src_ticks[pend_q]) begin
                    active_d = pend_q;
                    state_d  = SW_RUN;
                end
            end
            default: state_d = SW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SW_RUN;
            active_q <= SRC_OSCDIV;
            pend_q   <= SRC_OSCDIV;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
            pend_q   <= pend_d;
        end
    end

    always_comb begin
        sys_tick = 1'b0;
        unique case (state_q)
            SW_RUN, SW_DRAIN: sys_tick = src_ticks[active_q];
            SW_ARM:           sys_tick = 1'b0;
            default:          sys_tick = 1'b0;
        endcase
        active_src = active_q;
        busy       = (state_q != SW_RUN);
    end

    // Active source only changes out of the arm state (R10)
    assert_commit_from_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> ($past(state_q) == SW_ARM));

    // Busy only rises after an accepted request (R9)
    assert_busy_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_valid) && ($past(req_src) != $past(active_q))));

    // No system strobe while armed and waiting (R10)
    assert_quiet_when_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(state_q) && (state_q == SW_ARM)) |-> !sys_tick);

endmodule

// File: rtl/sys_clock_tree.sv
module sys_clock_tree
    import clktree_pkg::*;
#(
    parameter int OSC_MAX_LOG2 = 7,
    parameter int AHB_MAX_LOG2 = 9,
    parameter int APB_MAX_LOG2 = 4,
    parameter int KER_MAX_LOG2 = 3,
    parameter int CODE_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              hse_tick,
    input  logic              lsi_tick,
    input  logic              lse_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic              sys_tick,
    output logic              ahb_tick,
    output logic              ahb8_tick,
    output logic              apb_tick,
    output logic              tim_tick,
    output logic              ker_tick,
    output logic [1:0]        active_src,
    output logic              switch_busy
);
    localparam int OSC_RESET_CODE = 2;
    localparam int AHB8_LOG2      = 3;

    logic              ld_src, ld_osc, ld_ahb, ld_apb, ld_ker;
    logic              osc_div_tick, tim_div_tick;
    logic [3:0]        src_ticks;
    logic [CODE_W-1:0] apb_new, tim_new;
    logic              apb_is_one_q;

    always_comb begin
        ld_src = wr_en && (wr_addr == ADDR_SRC);
        ld_osc = wr_en && (wr_addr == ADDR_OSC);
        ld_ahb = wr_en && (wr_addr == ADDR_AHB);
        ld_apb = wr_en && (wr_addr == ADDR_APB);
        ld_ker = wr_en && (wr_addr == ADDR_KER);
        apb_new = (32'(wr_data) > 32'(APB_MAX_LOG2)) ? CODE_W'(APB_MAX_LOG2) : wr_data;
        tim_new = (apb_new == '0) ? '0 : apb_new - 1'b1;
    end

    ct_pow2_div #(.MAX_LOG2(OSC_MAX_LOG2), .CODE_W(CODE_W), .RESET_CODE(OSC_RESET_CODE)) u_osc_div (
        .clk(clk), .rst_n(rst_n), .in_tick(osc_tick), .load(ld_osc),
        .load_code(wr_data), .out_tick(osc_div_tick));

    assign src_ticks = {lse_tick, lsi_tick, hse_tick, osc_div_tick};

    ct_src_switch u_switch (
        .clk(clk), .rst_n(rst_n), .src_ticks(src_ticks), .req_valid(ld_src),
        .req_src(wr_data[1:0]), .sys_tick(sys_tick), .active_src(active_src),
        .busy(switch_busy));

    ct_pow2_div #(.MAX_LOG2(AHB_MAX_LOG2), .CODE_W(CODE_W), .RESET_CODE(0)) u_ahb_div (
        .clk(clk), .rst_n(rst_n), .in_tick(sys_tick), .load(ld_ahb),
        .load_code(wr_data), .out_tick(ahb_tick));

    ct_pow2_div #(.MAX_LOG2(AHB8_LOG2), .CODE_W(CODE_W), .RESET_CODE(AHB8_LOG2)) u_ahb8_div (
        .clk(clk), .rst_n(rst_n), .in_tick(ahb_tick), .load(1'b0),
        .load_code('0), .out_tick(ahb8_tick));

    ct_pow2_div #(.MAX_LOG2(APB_MAX_LOG2), .CODE_W(CODE_W), .RESET_CODE(0)) u_apb_div (
        .clk(clk), .rst_n(rst_n), .in_tick(ahb_tick), .load(ld_apb),
        .load_code(wr_data), .out_tick(apb_tick));

    ct_pow2_div #(.MAX_LOG2(APB_MAX_LOG2), .CODE_W(CODE_W), .RESET_CODE(0)) u_tim_div (
        .clk(clk), .rst_n(rst_n), .in_tick(ahb_tick), .load(ld_apb),
        .load_code(tim_new), .out_tick(tim_div_tick));

    ct_pow2_div #(.MAX_LOG2(KER_MAX_LOG2), .CODE_W(CODE_W), .RESET_CODE(0)) u_ker_div (
        .clk(clk), .rst_n(rst_n), .in_tick(osc_tick), .load(ld_ker),
        .load_code(wr_data), .out_tick(ker_tick));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      apb_is_one_q <= 1'b1;
        else if (ld_apb) apb_is_one_q <= (apb_new == '0);
    end

    assign tim_tick = apb_is_one_q ? apb_tick : tim_div_tick;

    // Every peripheral strobe coincides with a timer strobe (R7)
    assert_tim_covers_apb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        apb_tick |-> tim_tick);

    // Divide-by-eight tap only fires with a bus strobe (R5)
    assert_ahb8_on_ahb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ahb8_tick |-> ahb_tick);

    // Bus strobes only follow system strobes (R4)
    assert_ahb_on_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_tick |-> sys_tick);

endmodule

// File: tb/sys_clock_tree_tb.sv
module sys_clock_tree_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0, hse_tick = 1'b0, lsi_tick = 1'b0, lse_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       sys_tick, ahb_tick, ahb8_tick, apb_tick, tim_tick, ker_tick;
    logic [1:0] active_src;
    logic       switch_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // primary source periods and phases
    int per [4] = '{1, 3, 37, 29};
    int ph  [4] = '{0, 0, 0, 0};

    // reference model state
    int m_osc_code = 2, m_ahb_code = 0, m_apb_code = 0, m_ker_code = 0;
    int m_osc_cnt = 0, m_ahb_cnt = 0, m_ahb8_cnt = 0, m_apb_cnt = 0, m_tim_cnt = 0, m_ker_cnt = 0;
    int m_state = 0, m_active = 0, m_pend = 0;
    int n_apb = 0, n_tim = 0;

    always #2.5 clk = ~clk;

    sys_clock_tree u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .hse_tick(hse_tick),
        .lsi_tick(lsi_tick), .lse_tick(lse_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sys_tick(sys_tick), .ahb_tick(ahb_tick), .ahb8_tick(ahb8_tick),
        .apb_tick(apb_tick), .tim_tick(tim_tick), .ker_tick(ker_tick),
        .active_src(active_src), .switch_busy(switch_busy));

    function automatic int satc(int c, int mx);
        return (c > mx) ? mx : c;
    endfunction

    task automatic chk(int got, int exp, string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int adv(int cnt, bit t, int f);
        if (!t) return cnt;
        return (cnt == f - 1) ? 0 : cnt + 1;
    endfunction

    task automatic step(bit we, int a, int d);
        bit t[4];
        bit e_osc, e_sys, e_ahb, e_ahb8, e_apb, e_tim, e_ker;
        int fo, fa, fp, fk;
        @(negedge clk);
        for (int i = 0; i < 4; i++) t[i] = (ph[i] == per[i] - 1);
        osc_tick = t[0]; hse_tick = t[1]; lsi_tick = t[2]; lse_tick = t[3];
        wr_en = we; wr_addr = 3'(a); wr_data = 4'(d);
        #1;
        fo = 1 << m_osc_code; fa = 1 << m_ahb_code; fp = 1 << m_apb_code; fk = 1 << m_ker_code;
        e_osc = t[0] && (m_osc_cnt == fo - 1);
        t[0]  = e_osc;
        e_sys = (m_state == 2) ? 1'b0 : t[m_active];
        e_ahb = e_sys && (m_ahb_cnt == fa - 1);
        e_ahb8 = e_ahb && (m_ahb8_cnt == 7);
        e_apb = e_ahb && (m_apb_cnt == fp - 1);
        e_tim = (fp == 1) ? e_apb : (e_ahb && (m_tim_cnt == fp / 2 - 1));
        e_ker = osc_tick && (m_ker_cnt == fk - 1);
        chk(sys_tick,  e_sys,  "R10 sys_tick");
        chk(ahb_tick,  e_ahb,  "R4 ahb_tick");
        chk(ahb8_tick, e_ahb8, "R5 ahb8_tick");
        chk(apb_tick,  e_apb,  "R6 apb_tick");
        chk(tim_tick,  e_tim,  "R7 tim_tick");
        chk(ker_tick,  e_ker,  "R8 ker_tick");
        chk(active_src, m_active, "R9 active_src");
        chk(switch_busy, (m_state != 0), "R10 switch_busy");
        n_apb += e_apb; n_tim += e_tim;
        // model update
        m_osc_cnt  = adv(m_osc_cnt, osc_tick, fo);
        m_ahb_cnt  = adv(m_ahb_cnt, e_sys, fa);
        m_ahb8_cnt = adv(m_ahb8_cnt, e_ahb, 8);
        m_apb_cnt  = adv(m_apb_cnt, e_ahb, fp);
        if (fp > 1) m_tim_cnt = adv(m_tim_cnt, e_ahb, fp / 2);
        m_ker_cnt  = adv(m_ker_cnt, osc_tick, fk);
        case (m_state)
            0: if (we && a == 0 && (d % 4) != m_active) begin m_pend = d % 4; m_state = 1; end
            1: if (t[m_active]) m_state = 2;
            default: if (t[m_pend]) begin m_active = m_pend; m_state = 0; end
        endcase
        if (we && a == 1) begin m_osc_code = satc(d, 7); m_osc_cnt = 0; end
        if (we && a == 2) begin m_ahb_code = satc(d, 9); m_ahb_cnt = 0; end
        if (we && a == 3) begin m_apb_code = satc(d, 4); m_apb_cnt = 0; m_tim_cnt = 0; end
        if (we && a == 4) begin m_ker_code = satc(d, 3); m_ker_cnt = 0; end
        for (int i = 0; i < 4; i++) ph[i] = (ph[i] >= per[i] - 1) ? 0 : ph[i] + 1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic wait_switch();
        for (int i = 0; i < 400 && (m_state != 0); i++) step(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(active_src, 0, "R1 reset active_src");
        chk(switch_busy, 0, "R1 reset busy");
        idle(200);                          // R1, R2: oscillator divided by 4
        step(1, 1, 0);  idle(100);          // R2 divide by 1
        step(1, 1, 9);  idle(600);          // R2 saturates at 128
        step(1, 1, 0);
        step(1, 2, 3);  step(1, 3, 2); idle(600);   // R3 restart, R4, R6
        step(1, 2, 12); idle(1600);                 // R4 saturates at 512
        step(1, 2, 0);
        for (int k = 0; k < 5; k++) begin step(1, 4, k * 2); idle(40); end   // R8
        step(1, 0, 1);  step(1, 0, 3); wait_switch(); idle(50);  // R9 ignore while busy
        chk(active_src, 1, "R9 active after ignored request");
        step(1, 0, 1);  idle(20);           // R9 same source ignored
        chk(switch_busy, 0, "R9 busy after same-source request");
        step(1, 0, 2);  wait_switch(); idle(300);   // R10 to low-speed internal
        step(1, 0, 3);  wait_switch(); idle(300);
        step(1, 5, 7);  step(1, 6, 3); step(1, 7, 1); idle(200);  // R11
        step(1, 0, 0);  wait_switch(); idle(50);
        per[0] = 2;
        step(1, 0, 1); wait_switch(); step(1, 0, 0); wait_switch(); idle(100);
        per[0] = 1;
        for (int c = 0; c < 6; c++) begin   // R7 timer doubling for each setting
            int f;
            f = 1 << satc(c, 4);
            step(1, 3, c);
            n_apb = 0; n_tim = 0;
            idle(64);
            chk(n_apb, 64 / f, "R6 apb count");
            chk(n_tim, (f == 1) ? 64 : 128 / f, "R7 tim count");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule